// File: doc/BRIEF.md
# Data-Transfer Execute Unit

This unit carries out the data-transfer instructions in the execute stage of a small pipelined core. It accepts one decoded instruction per cycle: the opcode, the destination register index, the 16-bit constant field, and the values of the two source registers. It drives a synchronous, word-wide data memory and returns a write-back value, index and enable to the register file.

The unit handles six operations. Two move whole words between memory and registers, using a base register plus a signed offset. Two put a 16-bit constant into a register, either in the low half or shifted into the high half. Two write such a constant straight to memory, at the byte address held in the destination register. Byte addresses must be word aligned. A request whose address has either of its two low bits set raises a flag, and no memory access or register write takes place.

Memory requests leave the unit one cycle after issue. Every register write-back appears two cycles after issue, so write-backs keep the order in which the instructions were issued. For a load, the data comes from the memory read that the unit started the cycle before. The unit accepts a new instruction every cycle.

Top module: `lsu_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_we`, `mem_re`, `rf_we` and `misalign` are low.
- R2: Opcode 010000 (load word) reads the word at byte address `rs_value` + sign-extended `op_imm`. In the cycle after issue, `mem_re` is high and `mem_addr` is the byte address shifted right by 2. In the cycle after that, `rf_we` is high, `rf_waddr` = `op_rd` and `rf_wdata` = `mem_rdata`.
- R3: Opcode 010001 (store word) raises `mem_we` in the cycle after issue. It drives `mem_wdata` = `rd_value`, at byte address `rs_value` + sign-extended `op_imm`. It never raises `rf_we`.
- R4: Opcode 010010 returns `op_imm` zero-extended, and opcode 010100 returns `op_imm` shifted left by 16 with the low 16 bits zero. In both cases `rf_we` is high with `rf_waddr` = `op_rd` two cycles after issue, and there is no memory access.
- R5: Opcode 010011 writes `op_imm` zero-extended to memory, and opcode 010101 writes `op_imm` shifted left by 16. In both cases the byte address is `rd_value`, `mem_we` is high in the cycle after issue, and `rf_we` is never raised.
- R6: If any memory-accessing opcode computes a byte address whose bits [1:0] are non-zero, `misalign` is high in the cycle after issue. In that case `mem_we` and `mem_re` stay low, memory is left unchanged, and `rf_we` stays low in the following cycle.
- R7: `mem_we` and `mem_re` are never high together. Loads never raise `mem_we`.
- R8: If `op_valid` is low, or the opcode is outside 010000–010101, the unit raises none of `mem_we`, `mem_re`, `rf_we` or `misalign`.
- R9: A negative offset wraps correctly. Offset 0xFFE8 from base 0x60 addresses byte 0x48.
- R10: Instructions can issue back to back. A load's write-back and the next instruction's memory access happen in the same cycle, and both are correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An instruction is issued this cycle |
| op_code | input | 6 | Opcode |
| op_rd | input | 5 | Destination register index |
| op_imm | input | 16 | Offset or constant field |
| rs_value | input | 32 | Base register value |
| rd_value | input | 32 | Destination register value (store data or store-constant address) |
| mem_addr | output | 30 | Word address to memory |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_re` |
| misalign | output | 1 | Misaligned request detected and suppressed |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index |
| rf_wdata | output | 32 | Register file write value |

## Verification
The case that needs care is two instructions meeting in one cycle. A load's register write-back, two cycles after its issue, lands in the same cycle as the memory access of the instruction issued right after it. The bench provokes this by issuing a load, a store to a neighbouring word and a constant load on consecutive cycles. In the shared cycle it checks that the load's index and data reach the register port while the store's address and data reach the memory port. It then reads the stored word back to confirm the write landed.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int XLEN    = 32;
    localparam int OPC_W   = 6;
    localparam int IDX_W   = 5;
    localparam int IMM_W   = 16;
    localparam int ALIGN_W = 2;
    localparam int WADDR_W = XLEN - ALIGN_W;

    localparam logic [OPC_W-1:0] OPC_LD_WORD  = 6'b010000;
    localparam logic [OPC_W-1:0] OPC_ST_WORD  = 6'b010001;
    localparam logic [OPC_W-1:0] OPC_LD_CLO   = 6'b010010;
    localparam logic [OPC_W-1:0] OPC_ST_CLO   = 6'b010011;
    localparam logic [OPC_W-1:0] OPC_LD_CHI   = 6'b010100;
    localparam logic [OPC_W-1:0] OPC_ST_CHI   = 6'b010101;

    typedef struct packed {
        logic               mem_we;
        logic               mem_re;
        logic               misalign;
        logic [WADDR_W-1:0] waddr;
        logic [XLEN-1:0]    wdata;
        logic               rf_en;
        logic               rf_from_mem;
        logic [IDX_W-1:0]   rf_idx;
        logic [XLEN-1:0]    rf_val;
    } lsu_req_t;

    typedef struct packed {
        logic             rf_en;
        logic             from_mem;
        logic [IDX_W-1:0] idx;
        logic [XLEN-1:0]  val;
    } lsu_wb_t;

    typedef struct packed {
        lsu_req_t s1;
        lsu_wb_t  s2;
    } lsu_state_t;

endpackage

// File: rtl/lsu_imm_ext.sv
module lsu_imm_ext
    import lsu_pkg::*;
(
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  sext,
    output logic [XLEN-1:0]  zext,
    output logic [XLEN-1:0]  upper
);
    localparam int PAD_W = XLEN - IMM_W;

    always_comb begin
        sext  = {{PAD_W{imm[IMM_W-1]}}, imm};
        zext  = {{PAD_W{1'b0}}, imm};
        upper = zext << IMM_W;
    end
endmodule

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
(
    input  logic             op_valid,
    input  logic [OPC_W-1:0] opcode,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  rs_value,
    input  logic [XLEN-1:0]  rd_value,
    output lsu_req_t         req
);
    logic [XLEN-1:0] c_sext;
    logic [XLEN-1:0] c_zext;
    logic [XLEN-1:0] c_upper;
    logic [XLEN-1:0] byte_addr;

    lsu_imm_ext u_ext (
        .imm   (imm),
        .sext  (c_sext),
        .zext  (c_zext),
        .upper (c_upper)
    );

    always_comb begin
        req        = '0;
        req.rf_idx = rd_idx;
        byte_addr  = rs_value + c_sext;
        if (op_valid) begin
            case (opcode)
                OPC_LD_WORD: begin
                    req.mem_re      = 1'b1;
                    req.rf_en       = 1'b1;
                    req.rf_from_mem = 1'b1;
                end
                OPC_ST_WORD: begin
                    req.mem_we = 1'b1;
                    req.wdata  = rd_value;
                end
                OPC_LD_CLO: begin
                    req.rf_en  = 1'b1;
                    req.rf_val = c_zext;
                end
                OPC_LD_CHI: begin
                    req.rf_en  = 1'b1;
                    req.rf_val = c_upper;
                end
                OPC_ST_CLO: begin
                    byte_addr  = rd_value;
                    req.mem_we = 1'b1;
                    req.wdata  = c_zext;
                end
                OPC_ST_CHI: begin
                    byte_addr  = rd_value;
                    req.mem_we = 1'b1;
                    req.wdata  = c_upper;
                end
                default: ;
            endcase
        end
        if ((req.mem_we || req.mem_re) && (byte_addr[ALIGN_W-1:0] != '0)) begin
            req.misalign    = 1'b1;
            req.mem_we      = 1'b0;
            req.mem_re      = 1'b0;
            req.rf_en       = 1'b0;
            req.rf_from_mem = 1'b0;
        end
        req.waddr = byte_addr[XLEN-1:ALIGN_W];
    end

    always_comb begin
        assert (!(req.mem_we && req.mem_re)); // R7
    end
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
    import lsu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [OPC_W-1:0]   op_code,
    input  logic [IDX_W-1:0]   op_rd,
    input  logic [IMM_W-1:0]   op_imm,
    input  logic [XLEN-1:0]    rs_value,
    input  logic [XLEN-1:0]    rd_value,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [XLEN-1:0]    mem_wdata,
    output logic               mem_we,
    output logic               mem_re,
    input  logic [XLEN-1:0]    mem_rdata,
    output logic               misalign,
    output logic               rf_we,
    output logic [IDX_W-1:0]   rf_waddr,
    output logic [XLEN-1:0]    rf_wdata
);
    lsu_req_t   dec_req;
    lsu_state_t st_d;
    lsu_state_t st_q;

    lsu_decode u_dec (
        .op_valid (op_valid),
        .opcode   (op_code),
        .rd_idx   (op_rd),
        .imm      (op_imm),
        .rs_value (rs_value),
        .rd_value (rd_value),
        .req      (dec_req)
    );

    always_comb begin
        st_d             = st_q;
        st_d.s1          = dec_req;
        st_d.s2.rf_en    = st_q.s1.rf_en;
        st_d.s2.from_mem = st_q.s1.rf_from_mem;
        st_d.s2.idx      = st_q.s1.rf_idx;
        st_d.s2.val      = st_q.s1.rf_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_addr  = st_q.s1.waddr;
    assign mem_wdata = st_q.s1.wdata;
    assign mem_we    = st_q.s1.mem_we;
    assign mem_re    = st_q.s1.mem_re;
    assign misalign  = st_q.s1.misalign;
    assign rf_we     = st_q.s2.rf_en;
    assign rf_waddr  = st_q.s2.idx;
    assign rf_wdata  = st_q.s2.from_mem ? mem_rdata : st_q.s2.val;

    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R7
    AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_we && !mem_re)); // R6
    AST_MISALIGN_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> !rf_we); // R6
    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !rf_we); // R3
    AST_READ_THEN_WB: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> rf_we); // R2
endmodule

// File: tb/lsu_unit_test.sv
`timescale 1ns/1ps
module lsu_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [5:0]  op_code = '0;
    logic [4:0]  op_rd = '0;
    logic [15:0] op_imm = '0;
    logic [31:0] rs_value = '0;
    logic [31:0] rd_value = '0;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_we;
    logic        mem_re;
    logic [31:0] mem_rdata = '0;
    logic        misalign;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] mem [0:63];

    always #2 clk = ~clk;

    lsu_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_rd(op_rd), .op_imm(op_imm), .rs_value(rs_value), .rd_value(rd_value),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .misalign(misalign), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[5:0]];
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic put(logic [5:0] op, logic [4:0] rd, logic [15:0] imm,
                       logic [31:0] rs, logic [31:0] rdv);
        op_valid = 1'b1; op_code = op; op_rd = rd; op_imm = imm;
        rs_value = rs; rd_value = rdv;
        @(negedge clk);
    endtask

    task automatic quiet();
        op_valid = 1'b0;
    endtask

    task automatic chk_s1(string req, logic we, logic re, logic mis,
                          logic [29:0] addr, logic [31:0] wd);
        chk(req, "mem_we", 32'(mem_we), 32'(we));
        chk(req, "mem_re", 32'(mem_re), 32'(re));
        chk(req, "misalign", 32'(misalign), 32'(mis));
        if (we || re) chk(req, "mem_addr", 32'(mem_addr), 32'(addr));
        if (we) chk(req, "mem_wdata", mem_wdata, wd);
    endtask

    task automatic chk_wb(string req, logic we, logic [4:0] idx, logic [31:0] val);
        chk(req, "rf_we", 32'(rf_we), 32'(we));
        if (we) begin
            chk(req, "rf_waddr", 32'(rf_waddr), 32'(idx));
            chk(req, "rf_wdata", rf_wdata, val);
        end
    endtask

    task automatic read_word(string req, logic [31:0] baddr, logic [31:0] exp);
        put(6'b010000, 5'd2, 16'h0000, baddr, 32'h0);
        quiet();
        @(negedge clk);
        chk_wb(req, 1'b1, 5'd2, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "mem_we in reset", 32'(mem_we), 32'h0);
        chk("R1", "rf_we in reset", 32'(rf_we), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_s1("R1", 1'b0, 1'b0, 1'b0, '0, '0);
        chk_wb("R1", 1'b0, '0, '0);
    endtask

    task automatic t_store_load();
        put(6'b010001, 5'd1, 16'h0008, 32'h40, 32'hDEADBEEF);
        quiet();
        chk_s1("R3", 1'b1, 1'b0, 1'b0, 30'd18, 32'hDEADBEEF);
        @(negedge clk);
        chk_wb("R3", 1'b0, '0, '0);
        put(6'b010000, 5'd7, 16'h0000, 32'h48, 32'h0);
        quiet();
        chk_s1("R2", 1'b0, 1'b1, 1'b0, 30'd18, '0);
        @(negedge clk);
        chk_wb("R2", 1'b1, 5'd7, 32'hDEADBEEF);
        chk("R7", "mem_we on load", 32'(mem_we), 32'h0);
    endtask

    task automatic t_neg_offset();
        put(6'b010000, 5'd11, 16'hFFE8, 32'h60, 32'h0);
        quiet();
        chk_s1("R9", 1'b0, 1'b1, 1'b0, 30'd18, '0);
        @(negedge clk);
        chk_wb("R9", 1'b1, 5'd11, 32'hDEADBEEF);
    endtask

    task automatic t_const_loads();
        put(6'b010010, 5'd3, 16'h8001, 32'h0, 32'h0);
        quiet();
        chk_s1("R4", 1'b0, 1'b0, 1'b0, '0, '0);
        @(negedge clk);
        chk_wb("R4", 1'b1, 5'd3, 32'h00008001);
        put(6'b010100, 5'd4, 16'h8001, 32'h0, 32'h0);
        quiet();
        chk_s1("R4", 1'b0, 1'b0, 1'b0, '0, '0);
        @(negedge clk);
        chk_wb("R4", 1'b1, 5'd4, 32'h80010000);
    endtask

    task automatic t_const_stores();
        put(6'b010011, 5'd5, 16'hABCD, 32'h0, 32'h20);
        quiet();
        chk_s1("R5", 1'b1, 1'b0, 1'b0, 30'd8, 32'h0000ABCD);
        @(negedge clk);
        chk_wb("R5", 1'b0, '0, '0);
        put(6'b010101, 5'd5, 16'hABCD, 32'h0, 32'h24);
        quiet();
        chk_s1("R5", 1'b1, 1'b0, 1'b0, 30'd9, 32'hABCD0000);
        @(negedge clk);
        chk_wb("R5", 1'b0, '0, '0);
        read_word("R5", 32'h20, 32'h0000ABCD);
        read_word("R5", 32'h24, 32'hABCD0000);
    endtask

    task automatic t_misalign();
        put(6'b010001, 5'd1, 16'h0000, 32'h49, 32'h11112222);
        quiet();
        chk_s1("R6", 1'b0, 1'b0, 1'b1, '0, '0);
        @(negedge clk);
        chk_wb("R6", 1'b0, '0, '0);
        put(6'b010000, 5'd6, 16'h0002, 32'h48, 32'h0);
        quiet();
        chk_s1("R6", 1'b0, 1'b0, 1'b1, '0, '0);
        @(negedge clk);
        chk_wb("R6", 1'b0, '0, '0);
        put(6'b010011, 5'd6, 16'h1234, 32'h0, 32'h23);
        quiet();
        chk_s1("R6", 1'b0, 1'b0, 1'b1, '0, '0);
        @(negedge clk);
        read_word("R6", 32'h48, 32'hDEADBEEF);
    endtask

    task automatic t_ignored();
        put(6'b010110, 5'd8, 16'h0004, 32'h40, 32'h40);
        put(6'b011111, 5'd8, 16'h0004, 32'h40, 32'h40);
        chk_s1("R8", 1'b0, 1'b0, 1'b0, '0, '0);
        chk_wb("R8", 1'b0, '0, '0);
        put(6'b000000, 5'd8, 16'h0001, 32'h40, 32'h40);
        chk_s1("R8", 1'b0, 1'b0, 1'b0, '0, '0);
        chk_wb("R8", 1'b0, '0, '0);
        put(6'b010001, 5'd8, 16'h0000, 32'h40, 32'h0);
        op_valid = 1'b0;
        @(negedge clk);
        chk_s1("R8", 1'b0, 1'b0, 1'b0, '0, '0);
        chk_wb("R8", 1'b0, '0, '0);
        @(negedge clk);
        chk_wb("R8", 1'b0, '0, '0);
    endtask

    task automatic t_back_to_back();
        put(6'b010000, 5'd9, 16'h0000, 32'h48, 32'h0);
        chk_s1("R10", 1'b0, 1'b1, 1'b0, 30'd18, '0);
        put(6'b010001, 5'd1, 16'h000C, 32'h40, 32'h12345678);
        chk_s1("R10", 1'b1, 1'b0, 1'b0, 30'd19, 32'h12345678);
        chk_wb("R10", 1'b1, 5'd9, 32'hDEADBEEF);
        put(6'b010010, 5'd10, 16'h0055, 32'h0, 32'h0);
        quiet();
        chk_s1("R10", 1'b0, 1'b0, 1'b0, '0, '0);
        chk_wb("R10", 1'b0, '0, '0);
        @(negedge clk);
        chk_wb("R10", 1'b1, 5'd10, 32'h00000055);
        read_word("R10", 32'h4C, 32'h12345678);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        t_reset();
        t_store_load();
        t_neg_offset();
        t_const_loads();
        t_const_stores();
        t_misalign();
        t_ignored();
        t_back_to_back();
        finish_run();
    end

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule